// File: doc/BRIEF.md
# Locked-Rotor Watchdog Timer

This block guards a three-phase motor driver against a stalled rotor. While the driver reports that it is actively driving, it watches the three Hall position sensors. If the 3-bit Hall code keeps the same value for a set number of ticks from a slow timebase, it raises a lock fault. The fault tells the surrounding drive logic to switch off the high-side gate outputs. The fault is latched. It stays set after the rotor starts moving again and clears only when the torque command falls to its low threshold, or on a full reset.

After every reset the block also holds off the drive for one whole timeout. During that start-up hold, speed control is not allowed. The timeout is a parameter counted in timebase ticks, so it can be set to cover the motor's start-up time. For example, about 108 ticks of a 360 Hz reference give roughly 0.3 s. The Hall inputs are asynchronous: they pass through a two-flop synchroniser and are then compared against a registered copy of the last code. The tick counter value is brought out so that the time left before a trip can be seen.

Top module: `lock_watchdog`

## Requirements
- R1: While reset is high, and on the first cycle after it, `startup_hold` is 1, `lock_fault` is 0 and `tick_count` is 0.
- R2: After reset, `startup_hold` stays 1 for exactly LOCK_TICKS cycles that have `tick_en` high. It falls on the edge of the LOCK_TICKS-th tick, and `tick_count` returns to 0 on that same edge. During the hold, Hall changes, `run_active` and `cmd_low` do not affect the count, and no fault can be raised.
- R3: Outside the hold and fault states, with `run_active` high and no Hall change, `tick_count` rises by one on each cycle with `tick_en` high and stays unchanged on cycles without it.
- R4: When `tick_en` is high while `tick_count` equals LOCK_TICKS-1 in the watch state, `lock_fault` becomes 1 and `tick_count` becomes 0 on that edge.
- R5: Any change of the 3-bit Hall code clears `tick_count` on the third rising edge after the change: two synchroniser stages, then the comparison against the registered copy.
- R6: While `run_active` is low outside the hold, `tick_count` is 0 and no fault is raised.
- R7: Once set, `lock_fault` stays 1 whatever the Hall inputs, ticks and `run_active` do, until `cmd_low` is high or reset is applied. Its counter reads 0 meanwhile.
- R8: `cmd_low` high in the fault state clears `lock_fault` on the next edge, without a new start-up hold, and counting restarts from 0. `cmd_low` has no effect in the hold or watch states.
- R9: Reset applied during a fault clears it and starts a new full start-up hold.
- R10: When a Hall-change clear and a tick fall on the same edge, the clear wins and `tick_count` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle pulse of the slow timebase |
| hall_in | input | 3 | Asynchronous Hall sensor code |
| run_active | input | 1 | High while the driver is in the run state |
| cmd_low | input | 1 | High while the torque command is at or below its low threshold |
| lock_fault | output | 1 | Latched locked-rotor fault; high-side drive must be off |
| startup_hold | output | 1 | High during the start-up hold after reset |
| tick_count | output | CNT_W | Ticks counted since the last restart |

## Verification
All three outputs come from registers. A tick or a change of control input therefore shows up one rising edge after it is applied. A Hall change shows up three edges after it is applied, because of the two synchroniser stages and the compare register.

The bench drives inputs on the falling edge and samples on the next falling edge. For the Hall-clear cases it checks the count after two edges, where it must be unchanged, and again after three, where it must be cleared. In the random phase a cycle-exact bench model holds its own copy of the synchroniser pipeline, so it applies the same latencies when it computes the expected value for every cycle.

// File: rtl/lrw_pkg.sv
package lrw_pkg;

    // Operating phase of the watchdog
    typedef enum logic [1:0] {
        LRW_HOLD   = 2'd0,
        LRW_WATCH  = 2'd1,
        LRW_LOCKED = 2'd2
    } lrw_state_e;

    // Command from the phase controller to the tick counter
    typedef struct packed {
        logic clear;
        logic advance;
    } lrw_cnt_ctl_t;

    // Counter width large enough to hold values 0 .. limit-1
    function automatic int lrw_cnt_w(input int limit);
        int w;
        w = 1;
        while ((1 << w) < limit) w++;
        return w;
    endfunction

    function automatic logic lrw_is_fault(input lrw_state_e s);
        return s == LRW_LOCKED;
    endfunction

    function automatic logic lrw_is_hold(input lrw_state_e s);
        return s == LRW_HOLD;
    endfunction

endpackage

// File: rtl/lrw_hall_sync.sv
module lrw_hall_sync #(
    parameter int HALL_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HALL_W-1:0] hall_raw,
    output logic [HALL_W-1:0] hall_code,
    output logic              hall_changed
);
    logic [HALL_W-1:0] stage_q [SYNC_STAGES];
    logic [HALL_W-1:0] last_q;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= '0;
                    else     stage_q[0] <= hall_raw;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= '0;
                    else     stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= '0;
        else     last_q <= stage_q[SYNC_STAGES-1];
    end

    assign hall_code    = last_q;
    assign hall_changed = (stage_q[SYNC_STAGES-1] != last_q);

endmodule

// File: rtl/lrw_tick_timer.sv
module lrw_tick_timer
    import lrw_pkg::*;
#(
    parameter int LOCK_TICKS = 108,
    parameter int CNT_W      = lrw_cnt_w(LOCK_TICKS)
) (
    input  logic             clk,
    input  logic             rst,
    input  lrw_cnt_ctl_t     ctl,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_TICKS - 1);

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_d;

    assign expire = ctl.advance && !ctl.clear && (count_q == LAST);

    always_comb begin
        count_d = count_q;
        if (ctl.clear)        count_d = '0;
        else if (expire)      count_d = '0;
        else if (ctl.advance) count_d = count_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) count_q <= '0;
        else     count_q <= count_d;
    end

    assign count = count_q;

endmodule

// File: rtl/lrw_ctrl.sv
module lrw_ctrl
    import lrw_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_en,
    input  logic         run_active,
    input  logic         cmd_low,
    input  logic         hall_changed,
    input  logic         expire,
    output lrw_cnt_ctl_t ctl,
    output logic         fault,
    output logic         hold
);
    lrw_state_e state_q, state_d;

    always_comb begin
        ctl     = '0;
        state_d = state_q;
        unique case (state_q)
            LRW_HOLD: begin
                ctl.advance = tick_en;
                if (expire) state_d = LRW_WATCH;
            end
            LRW_WATCH: begin
                ctl.clear   = !run_active || hall_changed;
                ctl.advance = tick_en;
                if (expire) state_d = LRW_LOCKED;
            end
            LRW_LOCKED: begin
                ctl.clear = 1'b1;
                if (cmd_low) state_d = LRW_WATCH;
            end
            default: begin
                ctl.clear = 1'b1;
                state_d   = LRW_HOLD;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= LRW_HOLD;
        else     state_q <= state_d;
    end

    assign fault = lrw_is_fault(state_q);
    assign hold  = lrw_is_hold(state_q);

endmodule

// File: rtl/lock_watchdog.sv
module lock_watchdog
    import lrw_pkg::*;
#(
    parameter int LOCK_TICKS  = 108,
    parameter int HALL_W      = 3,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = lrw_cnt_w(LOCK_TICKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic [HALL_W-1:0] hall_in,
    input  logic              run_active,
    input  logic              cmd_low,
    output logic              lock_fault,
    output logic              startup_hold,
    output logic [CNT_W-1:0]  tick_count
);
    logic [HALL_W-1:0] hall_code;
    logic              hall_changed;
    logic              expire;
    lrw_cnt_ctl_t      ctl;

    lrw_hall_sync #(.HALL_W(HALL_W), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .hall_raw(hall_in),
        .hall_code(hall_code), .hall_changed(hall_changed)
    );

    lrw_ctrl u_ctrl (
        .clk(clk), .rst(rst), .tick_en(tick_en), .run_active(run_active),
        .cmd_low(cmd_low), .hall_changed(hall_changed), .expire(expire),
        .ctl(ctl), .fault(lock_fault), .hold(startup_hold)
    );

    lrw_tick_timer #(.LOCK_TICKS(LOCK_TICKS), .CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .ctl(ctl), .count(tick_count), .expire(expire)
    );

    logic unused_code;
    assign unused_code = ^hall_code;

endmodule

// File: rtl/lock_watchdog_chk.sv
module lock_watchdog_chk #(
    parameter int LOCK_TICKS = 108,
    parameter int CNT_W      = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_en,
    input logic             run_active,
    input logic             cmd_low,
    input logic             lock_fault,
    input logic             startup_hold,
    input logic [CNT_W-1:0] tick_count
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_TICKS - 1);

    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        tick_count <= LAST);

    // R2
    hold_no_fault_chk: assert property (@(posedge clk) disable iff (rst)
        startup_hold |-> !lock_fault);

    // R2
    hold_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(startup_hold) |-> (tick_count == '0) && $past(tick_en));

    // R4
    trip_point_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_fault) |-> $past(tick_en) && ($past(tick_count) == LAST));

    // R6
    idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_active && !startup_hold && !lock_fault) |=> (tick_count == '0) && !lock_fault);

    // R7
    fault_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (lock_fault && !cmd_low) |=> lock_fault && (tick_count == '0));

    // R8
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (lock_fault && cmd_low) |=> !lock_fault && !startup_hold && (tick_count == '0));

endmodule

bind lock_watchdog lock_watchdog_chk #(.LOCK_TICKS(LOCK_TICKS), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .tick_en(tick_en), .run_active(run_active),
    .cmd_low(cmd_low), .lock_fault(lock_fault), .startup_hold(startup_hold),
    .tick_count(tick_count)
);

// File: tb/lock_watchdog_test.sv
module lock_watchdog_test;
    localparam int TB_TICKS = 20;
    localparam int CW       = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick_en = 1'b0;
    logic [2:0]    hall_in = 3'b101;
    logic          run_active = 1'b0;
    logic          cmd_low = 1'b0;
    logic          lock_fault;
    logic          startup_hold;
    logic [CW-1:0] tick_count;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    lock_watchdog #(.LOCK_TICKS(TB_TICKS)) uut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .hall_in(hall_in),
        .run_active(run_active), .cmd_low(cmd_low), .lock_fault(lock_fault),
        .startup_hold(startup_hold), .tick_count(tick_count)
    );

    // Bench reference model built from the requirements
    logic [2:0] m_s1, m_s2, m_q;
    int         m_st;   // 0 hold, 1 watch, 2 locked
    int         m_cnt;

    function automatic int next_cnt(int st, int cnt, bit tk, bit run, bit chg);
        if (st == 2) return 0;
        if (st == 1 && (!run || chg)) return 0;
        if (tk) return (cnt == TB_TICKS - 1) ? 0 : cnt + 1;
        return cnt;
    endfunction

    function automatic int next_st(int st, int cnt, bit tk, bit run, bit chg, bit cl);
        if (st == 0) return (tk && cnt == TB_TICKS - 1) ? 1 : 0;
        if (st == 1) return (run && !chg && tk && cnt == TB_TICKS - 1) ? 2 : 1;
        return cl ? 1 : 2;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_s1 <= 3'b0; m_s2 <= 3'b0; m_q <= 3'b0; m_st <= 0; m_cnt <= 0;
        end else begin
            m_s1  <= hall_in;
            m_s2  <= m_s1;
            m_q   <= m_s2;
            m_cnt <= next_cnt(m_st, m_cnt, tick_en, run_active, m_s2 != m_q);
            m_st  <= next_st(m_st, m_cnt, tick_en, run_active, m_s2 != m_q, cmd_low);
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic expect_out(input string req, input int cnt, input bit hold, input bit flt);
        check(tick_count == CW'(cnt), req, "tick_count", int'(tick_count), cnt);
        check(startup_hold == hold, req, "startup_hold", int'(startup_hold), int'(hold));
        check(lock_fault == flt, req, "lock_fault", int'(lock_fault), int'(flt));
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic tick_once();
        tick_en = 1'b1;
        step();
        tick_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick_once();
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            summary();
        end
    end

    initial begin
        void'($urandom(32'h5A17));
        step(); step(); step();
        expect_out("R1 in reset", 0, 1'b1, 1'b0);
        rst = 1'b0;
        step();
        expect_out("R1 after reset", 0, 1'b1, 1'b0);

        // R2: hold counts ticks regardless of Hall, run and cmd_low
        hall_in = 3'b011; step(); hall_in = 3'b010; step();
        cmd_low = 1'b1; step(); cmd_low = 1'b0;
        repeat (4) step();
        ticks(TB_TICKS - 1);
        expect_out("R2 hold pending", TB_TICKS - 1, 1'b1, 1'b0);
        tick_once();
        expect_out("R2 hold end", 0, 1'b0, 1'b0);

        // R3 counting, with R8 cmd_low ignored outside fault
        run_active = 1'b1; step();
        cmd_low = 1'b1; tick_once(); cmd_low = 1'b0;
        ticks(4);
        expect_out("R3 count/R8 cmd_low ignored", 5, 1'b0, 1'b0);
        repeat (3) step();
        expect_out("R3 no tick", 5, 1'b0, 1'b0);

        // R5 Hall change clears on third edge
        hall_in = 3'b110;
        step(); step();
        expect_out("R5 before clear", 5, 1'b0, 1'b0);
        step();
        expect_out("R5 clear", 0, 1'b0, 1'b0);
        step(); step();

        // R10 clear beats tick
        ticks(4);
        expect_out("R10 setup", 4, 1'b0, 1'b0);
        hall_in = 3'b100;
        step(); step();
        tick_once();
        expect_out("R10 clear wins", 0, 1'b0, 1'b0);
        step(); step();

        // R6 run low keeps counter idle
        run_active = 1'b0;
        ticks(3);
        expect_out("R6 idle", 0, 1'b0, 1'b0);
        run_active = 1'b1; step();

        // R4 trip
        ticks(TB_TICKS - 1);
        expect_out("R4 before trip", TB_TICKS - 1, 1'b0, 1'b0);
        tick_once();
        expect_out("R4 trip", 0, 1'b0, 1'b1);

        // R7 latched
        hall_in = 3'b001; repeat (4) step();
        ticks(3);
        run_active = 1'b0; step(); run_active = 1'b1; step();
        expect_out("R7 latched", 0, 1'b0, 1'b1);

        // R8 release
        cmd_low = 1'b1; step(); cmd_low = 1'b0;
        expect_out("R8 release", 0, 1'b0, 1'b0);
        tick_once();
        expect_out("R8 restart", 1, 1'b0, 1'b0);

        // R9 reset during fault
        ticks(TB_TICKS - 1);
        expect_out("R9 fault set", 0, 1'b0, 1'b1);
        rst = 1'b1; step(); rst = 1'b0; step();
        expect_out("R9 new hold", 0, 1'b1, 1'b0);

        // Random phase against the bench model (R2..R8)
        for (int c = 0; c < 6000; c++) begin
            check(tick_count == CW'(m_cnt), "R3 random", "tick_count", int'(tick_count), m_cnt);
            check(lock_fault == (m_st == 2), "R7 random", "lock_fault", int'(lock_fault), int'(m_st == 2));
            check(startup_hold == (m_st == 0), "R2 random", "startup_hold", int'(startup_hold), int'(m_st == 0));
            tick_en    = ($urandom % 3) == 0;
            if (($urandom % 40) == 0) hall_in = 3'($urandom);
            run_active = ($urandom % 20) != 0;
            cmd_low    = ($urandom % 30) == 0;
            rst        = ($urandom % 2000) == 0;
            step();
        end
        rst = 1'b0; tick_en = 1'b0;
        done = 1'b1;
        summary();
    end

endmodule